// File: doc/BRIEF.md
# Sixteen-Pin Port Expander Register Core

This block is the register side of a two-port, sixteen-pin I/O expander that sits behind a byte-oriented serial slave engine. The engine reports transaction boundaries and bytes. The core uses them to load a command pointer, and the pointer selects one of eight byte registers: two input ports, two output latches, two polarity masks and two direction masks. A write transaction carries the command byte and then any number of data bytes. A read is served from the register that the last command selected. After each data byte the pointer alternates between the two registers of its pair, so a burst walks port 0, port 1, port 0 and so on.

Pins are sampled through a two-flop synchronizer. A pin whose direction bit is 1 is an undriven input. A pin whose direction bit is 0 is driven from its output latch. Input reads always report the real pin level, optionally inverted per bit. Output reads report the latch and never the pin.

The control state machine has four states. ST_IDLE is entered after reset or on stop. ST_CMD waits for the command byte after a start. ST_DATA accepts register writes. ST_READ is entered on the first read request. The transitions are: start from any state goes to ST_CMD. Stop from any state goes to ST_IDLE. A written byte in ST_CMD goes to ST_DATA. A read request taken in ST_IDLE, ST_CMD or ST_DATA goes to ST_READ. ST_DATA holds on further written bytes, and ST_READ holds until the next start or stop. When several inputs are active in one cycle, start wins over stop, stop wins over a written byte, and a written byte wins over a read request.

Top module: `gpx_core`

## Requirements
- R1: During and after reset, both direction registers read 0xFF, both output latches read 0xFF and both polarity masks read 0x00. Every pin then has pin_oe_o low and pin_out_o low until a register is written.
- R2: The first byte written after start_i is taken as the command pointer, not as data. Later bytes written before stop_i go to the register the pointer selects: 2/3 output latch port 0/1, 4/5 polarity port 0/1, 6/7 direction port 0/1. Registers change only on a written data byte.
- R3: After each accepted data byte, written or read, a pointer in 0..7 toggles bit 0 (2→3→2, 6→7→6).
- R4: A read of pointer 0 or 1 returns the level that pin_i[7:0] or pin_i[15:8] had two clocks earlier. This holds whatever the direction bits are.
- R5: On an input port read, each bit whose polarity mask bit is 1 is returned inverted. A bit whose mask bit is 0 is returned as sampled.
- R6: Data bytes written to pointer 0 or 1 are accepted and advance the pointer but change no register.
- R7: A read of pointer 2 or 3 returns the output latch, even when the pin is an input or the pin level differs.
- R8: For each pin, pin_oe_o is the inverse of its direction bit. pin_out_o equals the latch bit when the pin is an output and 0 when it is an input.
- R9: A command of 8..255 makes written data bytes change nothing, makes reads return 0x00, and stops the pointer from advancing.
- R10: A read request that no start, stop or written byte overrides gives rd_valid_o high for exactly the next cycle, with rd_data_o valid in that cycle. rd_valid_o is low at all other times.
- R11: Bytes written in ST_IDLE (after stop) or in ST_READ are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset, holds defaults |
| start_i | input | 1 | Pulse: a write-addressed transaction begins |
| stop_i | input | 1 | Pulse: the transaction ends |
| wr_valid_i | input | 1 | A written byte is present on wr_data_i |
| wr_data_i | input | 8 | Written byte (command or data) |
| rd_req_i | input | 1 | Request for the next read byte |
| rd_data_o | output | 8 | Read byte, valid with rd_valid_o |
| rd_valid_o | output | 1 | Read byte strobe, one cycle after the request |
| pin_i | input | 16 | Pin levels, port 0 in bits 7:0 |
| pin_oe_o | output | 16 | Per-pin output enable, 1 drives the pin |
| pin_out_o | output | 16 | Per-pin drive value |

## Verification
Five properties are checked on every cycle. The read strobe must follow each accepted request one cycle later and never appear otherwise. An undriven pin must carry a low drive value. Pin outputs must stay stable in cycles without a written byte, and no pin may be enabled before the first write. A read with an out-of-range pointer must return zero and leave the pointer unchanged. Other behaviour can only be shown by the bench's scenarios against its reference model. That covers the two-cycle pin latency, polarity inversion, read-only input ports, latch-versus-pin readback, pointer toggling inside a pair, and bytes ignored after stop or during reads.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

    localparam int BYTE_W    = 8;
    localparam int NUM_PORTS = 2;
    localparam int NUM_REGS  = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMD  = 2'd1,
        ST_DATA = 2'd2,
        ST_READ = 2'd3
    } ctl_state_e;

    typedef enum logic [1:0] {
        GRP_IN  = 2'd0,
        GRP_OUT = 2'd1,
        GRP_POL = 2'd2,
        GRP_DIR = 2'd3
    } reg_grp_e;

endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] chain_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= '0;
                    else        chain_q[0] <= d_i;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/gpx_ctrl.sv
module gpx_ctrl
    import gpx_pkg::*;
#(
    parameter int CMD_W   = BYTE_W,
    parameter int REG_CNT = NUM_REGS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             wr_valid_i,
    input  logic [CMD_W-1:0] wr_data_i,
    input  logic             rd_req_i,
    output logic [CMD_W-1:0] ptr_o,
    output logic             reg_we_o,
    output logic             reg_re_o
);

    ctl_state_e       state_q, state_d;
    logic [CMD_W-1:0] ptr_q;
    logic             bnd;
    logic             wr_ev;
    logic             rd_ev;
    logic             cmd_ld;
    logic             ptr_in_map;

    assign bnd   = start_i | stop_i;
    assign wr_ev = wr_valid_i & ~bnd;
    assign rd_ev = rd_req_i & ~wr_valid_i & ~bnd;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (start_i) begin
            state_d = ST_CMD;
        end else if (stop_i) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (rd_ev) state_d = ST_READ;
                ST_CMD: begin
                    if (wr_ev)      state_d = ST_DATA;
                    else if (rd_ev) state_d = ST_READ;
                end
                ST_DATA: if (rd_ev) state_d = ST_READ;
                ST_READ: state_d = ST_READ;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        cmd_ld   = 1'b0;
        reg_we_o = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_CMD:  cmd_ld   = wr_ev;
            ST_DATA: reg_we_o = wr_ev;
            ST_READ: ;
            default: ;
        endcase
        reg_re_o = rd_ev;
    end

    assign ptr_in_map = (ptr_q < CMD_W'(REG_CNT));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (cmd_ld) begin
            ptr_q <= wr_data_i;
        end else if ((reg_we_o || reg_re_o) && ptr_in_map) begin
            ptr_q <= {ptr_q[CMD_W-1:1], ~ptr_q[0]};
        end
    end

    assign ptr_o = ptr_q;

endmodule

// File: rtl/gpx_regbank.sv
module gpx_regbank
    import gpx_pkg::*;
#(
    parameter int PORT_W = BYTE_W,
    parameter int PORTS  = NUM_PORTS,
    parameter int CMD_W  = BYTE_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [CMD_W-1:0]        ptr_i,
    input  logic                    we_i,
    input  logic                    re_i,
    input  logic [PORT_W-1:0]       wdata_i,
    input  logic [PORTS*PORT_W-1:0] pin_sync_i,
    output logic [PORT_W-1:0]       rd_data_o,
    output logic                    rd_valid_o,
    output logic [PORTS*PORT_W-1:0] pin_oe_o,
    output logic [PORTS*PORT_W-1:0] pin_out_o
);

    localparam int PIN_W = PORTS * PORT_W;
    localparam logic [PORT_W-1:0] LATCH_RST = '1;
    localparam logic [PORT_W-1:0] POL_RST   = '0;
    localparam logic [PORT_W-1:0] DIR_RST   = '1;

    logic [PIN_W-1:0] out_flat;
    logic [PIN_W-1:0] pol_flat;
    logic [PIN_W-1:0] dir_flat;
    logic             in_map;
    reg_grp_e         grp;
    logic             port_sel;
    logic [PORT_W-1:0] rd_mux;

    assign in_map   = (ptr_i < CMD_W'(NUM_REGS));
    assign grp      = reg_grp_e'(ptr_i[2:1]);
    assign port_sel = ptr_i[0];

    generate
        for (genvar p = 0; p < PORTS; p++) begin : g_port
            logic [PORT_W-1:0] latch_q;
            logic [PORT_W-1:0] pol_q;
            logic [PORT_W-1:0] dir_q;
            logic              hit;

            assign hit = we_i && in_map && (port_sel == p[0]);

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    latch_q <= LATCH_RST;
                    pol_q   <= POL_RST;
                    dir_q   <= DIR_RST;
                end else if (hit) begin
                    unique case (grp)
                        GRP_IN:  ;
                        GRP_OUT: latch_q <= wdata_i;
                        GRP_POL: pol_q   <= wdata_i;
                        GRP_DIR: dir_q   <= wdata_i;
                        default: ;
                    endcase
                end
            end

            assign out_flat[p*PORT_W +: PORT_W]  = latch_q;
            assign pol_flat[p*PORT_W +: PORT_W]  = pol_q;
            assign dir_flat[p*PORT_W +: PORT_W]  = dir_q;
            assign pin_oe_o[p*PORT_W +: PORT_W]  = ~dir_q;
            assign pin_out_o[p*PORT_W +: PORT_W] = latch_q & ~dir_q;
        end
    endgenerate

    always_comb begin
        rd_mux = '0;
        if (in_map) begin
            unique case (grp)
                GRP_IN:  rd_mux = pin_sync_i[port_sel*PORT_W +: PORT_W]
                                ^ pol_flat[port_sel*PORT_W +: PORT_W];
                GRP_OUT: rd_mux = out_flat[port_sel*PORT_W +: PORT_W];
                GRP_POL: rd_mux = pol_flat[port_sel*PORT_W +: PORT_W];
                GRP_DIR: rd_mux = dir_flat[port_sel*PORT_W +: PORT_W];
                default: rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data_o  <= '0;
            rd_valid_o <= 1'b0;
        end else begin
            rd_valid_o <= re_i;
            if (re_i) rd_data_o <= rd_mux;
        end
    end

endmodule

// File: rtl/gpx_core.sv
module gpx_core
    import gpx_pkg::*;
#(
    parameter int PORT_W      = BYTE_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_i,
    input  logic                          stop_i,
    input  logic                          wr_valid_i,
    input  logic [PORT_W-1:0]             wr_data_i,
    input  logic                          rd_req_i,
    output logic [PORT_W-1:0]             rd_data_o,
    output logic                          rd_valid_o,
    input  logic [NUM_PORTS*PORT_W-1:0]   pin_i,
    output logic [NUM_PORTS*PORT_W-1:0]   pin_oe_o,
    output logic [NUM_PORTS*PORT_W-1:0]   pin_out_o
);

    localparam int PIN_W = NUM_PORTS * PORT_W;

    logic [PIN_W-1:0]  pin_sync;
    logic [PORT_W-1:0] cmd_ptr;
    logic              reg_we;
    logic              reg_re;

    gpx_sync #(
        .WIDTH  (PIN_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_i),
        .q_o   (pin_sync)
    );

    gpx_ctrl #(
        .CMD_W   (PORT_W),
        .REG_CNT (NUM_REGS)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .stop_i     (stop_i),
        .wr_valid_i (wr_valid_i),
        .wr_data_i  (wr_data_i),
        .rd_req_i   (rd_req_i),
        .ptr_o      (cmd_ptr),
        .reg_we_o   (reg_we),
        .reg_re_o   (reg_re)
    );

    gpx_regbank #(
        .PORT_W (PORT_W),
        .PORTS  (NUM_PORTS),
        .CMD_W  (PORT_W)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .ptr_i      (cmd_ptr),
        .we_i       (reg_we),
        .re_i       (reg_re),
        .wdata_i    (wr_data_i),
        .pin_sync_i (pin_sync),
        .rd_data_o  (rd_data_o),
        .rd_valid_o (rd_valid_o),
        .pin_oe_o   (pin_oe_o),
        .pin_out_o  (pin_out_o)
    );

endmodule

// File: rtl/gpx_core_chk.sv
module gpx_core_chk #(
    parameter int PORT_W = 8,
    parameter int PIN_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              stop_i,
    input logic              wr_valid_i,
    input logic              rd_req_i,
    input logic              rd_valid_o,
    input logic [PORT_W-1:0] rd_data_o,
    input logic [PIN_W-1:0]  pin_oe_o,
    input logic [PIN_W-1:0]  pin_out_o,
    input logic [PORT_W-1:0] cmd_ptr
);

    logic wr_seen_q;
    logic rd_take;

    assign rd_take = rd_req_i && !wr_valid_i && !start_i && !stop_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          wr_seen_q <= 1'b0;
        else if (wr_valid_i) wr_seen_q <= 1'b1;
    end

    p_no_drive_before_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_seen_q |-> (pin_oe_o == '0));

    p_pins_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid_i |=> ($stable(pin_oe_o) && $stable(pin_out_o)));

    p_undriven_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_out_o & ~pin_oe_o) == '0));

    p_read_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_take |=> rd_valid_o);

    p_no_spurious_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_take |=> !rd_valid_o);

    p_high_cmd_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_take && cmd_ptr >= PORT_W'(8)) |=> (rd_data_o == '0 && $stable(cmd_ptr)));

endmodule

bind gpx_core gpx_core_chk #(
    .PORT_W (PORT_W),
    .PIN_W  (PIN_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .stop_i     (stop_i),
    .wr_valid_i (wr_valid_i),
    .rd_req_i   (rd_req_i),
    .rd_valid_o (rd_valid_o),
    .rd_data_o  (rd_data_o),
    .pin_oe_o   (pin_oe_o),
    .pin_out_o  (pin_out_o),
    .cmd_ptr    (cmd_ptr)
);

// File: tb/test_gpx_core.sv
module test_gpx_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        stop_i = 1'b0;
    logic        wr_valid_i = 1'b0;
    logic [7:0]  wr_data_i = 8'h00;
    logic        rd_req_i = 1'b0;
    logic [7:0]  rd_data_o;
    logic        rd_valid_o;
    logic [15:0] pin_i = 16'h0000;
    logic [15:0] pin_oe_o;
    logic [15:0] pin_out_o;

    int vectors = 0;
    int fails = 0;
    string cur_req = "R1";

    // reference model state
    logic [7:0]  m_latch [2];
    logic [7:0]  m_pol [2];
    logic [7:0]  m_dir [2];
    logic [15:0] m_s1, m_s2;
    int          m_ptr;
    int          m_mode;   // 0 idle, 1 awaiting command, 2 data, 3 reading
    logic        m_rv;
    logic [7:0]  m_rd;

    always #4 clk = ~clk;

    gpx_core i_gpx_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .stop_i     (stop_i),
        .wr_valid_i (wr_valid_i),
        .wr_data_i  (wr_data_i),
        .rd_req_i   (rd_req_i),
        .rd_data_o  (rd_data_o),
        .rd_valid_o (rd_valid_o),
        .pin_i      (pin_i),
        .pin_oe_o   (pin_oe_o),
        .pin_out_o  (pin_out_o)
    );

    function automatic logic [7:0] model_read();
        int g, p;
        if (m_ptr > 7) return 8'h00;
        g = m_ptr / 2;
        p = m_ptr % 2;
        case (g)
            0: return (p == 0 ? m_s2[7:0] : m_s2[15:8]) ^ m_pol[p];
            1: return m_latch[p];
            2: return m_pol[p];
            default: return m_dir[p];
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                m_latch[i] = 8'hFF; m_pol[i] = 8'h00; m_dir[i] = 8'hFF;
            end
            m_s1 = '0; m_s2 = '0; m_ptr = 0; m_mode = 0; m_rv = 0; m_rd = 8'h00;
        end else begin
            m_rv = 1'b0;
            if (start_i) begin
                m_mode = 1;
            end else if (stop_i) begin
                m_mode = 0;
            end else if (wr_valid_i) begin
                if (m_mode == 1) begin
                    m_ptr = int'(wr_data_i);
                    m_mode = 2;
                end else if (m_mode == 2) begin
                    if (m_ptr < 8) begin
                        case (m_ptr / 2)
                            1: m_latch[m_ptr % 2] = wr_data_i;
                            2: m_pol[m_ptr % 2]   = wr_data_i;
                            3: m_dir[m_ptr % 2]   = wr_data_i;
                            default: ;
                        endcase
                        m_ptr = m_ptr ^ 1;
                    end
                end
            end else if (rd_req_i) begin
                m_rv = 1'b1;
                m_rd = model_read();
                if (m_ptr < 8) m_ptr = m_ptr ^ 1;
                m_mode = 3;
            end
            m_s2 = m_s1;
            m_s1 = pin_i;
        end
    end

    always @(negedge clk) begin
        if (rst_n !== 1'bx) begin
            vectors++;
            if (rd_valid_o !== m_rv) begin
                fails++;
                $display("FAIL R10 rd_valid_o actual %b expected %b", rd_valid_o, m_rv);
            end else if (m_rv && rd_data_o !== m_rd) begin
                fails++;
                $display("FAIL %s rd_data_o actual %h expected %h", cur_req, rd_data_o, m_rd);
            end
            if (pin_oe_o !== ~{m_dir[1], m_dir[0]}) begin
                fails++;
                $display("FAIL R8 pin_oe_o actual %h expected %h", pin_oe_o, ~{m_dir[1], m_dir[0]});
            end
            if (pin_out_o !== ({m_latch[1], m_latch[0]} & ~{m_dir[1], m_dir[0]})) begin
                fails++;
                $display("FAIL R8 pin_out_o actual %h expected %h", pin_out_o,
                         {m_latch[1], m_latch[0]} & ~{m_dir[1], m_dir[0]});
            end
        end
    end

    task automatic step(input logic s, input logic p, input logic w,
                        input logic [7:0] d, input logic r);
        @(negedge clk);
        start_i = s; stop_i = p; wr_valid_i = w; wr_data_i = d; rd_req_i = r;
    endtask

    task automatic idle(input int n);
        repeat (n) step(1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
    endtask

    task automatic wr_pair(input logic [7:0] cmd, input logic [7:0] b0, input logic [7:0] b1);
        step(1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
        step(1'b0, 1'b0, 1'b1, cmd, 1'b0);
        step(1'b0, 1'b0, 1'b1, b0, 1'b0);
        step(1'b0, 1'b0, 1'b1, b1, 1'b0);
        step(1'b0, 1'b1, 1'b0, 8'h00, 1'b0);
        idle(2);
    endtask

    task automatic rd_burst(input logic [7:0] cmd, input int n);
        step(1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
        step(1'b0, 1'b0, 1'b1, cmd, 1'b0);
        for (int k = 0; k < n; k++) step(1'b0, 1'b0, 1'b0, 8'h00, 1'b1);
        step(1'b0, 1'b1, 1'b0, 8'h00, 1'b0);
        idle(2);
    endtask

    task automatic set_pins(input logic [15:0] v);
        @(negedge clk);
        pin_i = v;
        idle(3);
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        pin_i = 16'hA55A;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        idle(3);

        cur_req = "R1";   // defaults of all registers
        for (int c = 0; c < 8; c++) rd_burst(8'(c), 1);

        cur_req = "R2";   // command then two data bytes into the latch pair
        wr_pair(8'h02, 8'hA5, 8'h3C);
        rd_burst(8'h02, 2);

        cur_req = "R3";   // pointer alternates inside the pair
        rd_burst(8'h03, 4);
        wr_pair(8'h07, 8'hF0, 8'h0F);   // writes 7 then 6
        rd_burst(8'h06, 3);

        cur_req = "R8";   // direction patterns drive latches onto pins
        wr_pair(8'h06, 8'h00, 8'hFF);
        wr_pair(8'h06, 8'h0F, 8'h00);
        wr_pair(8'h02, 8'h96, 8'h69);

        cur_req = "R7";   // latch readback while pins differ
        set_pins(16'h0000);
        rd_burst(8'h02, 2);
        wr_pair(8'h06, 8'hFF, 8'hFF);
        rd_burst(8'h02, 2);

        cur_req = "R4";   // input reads follow pins, regardless of direction
        set_pins(16'h12C3);
        rd_burst(8'h00, 2);
        wr_pair(8'h06, 8'h00, 8'h00);
        set_pins(16'hFE01);
        rd_burst(8'h00, 3);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            pin_i = 16'($urandom);
            rd_burst(8'(k % 2), 2);
        end

        cur_req = "R5";   // polarity masks
        wr_pair(8'h04, 8'hFF, 8'h0F);
        set_pins(16'h5A5A);
        rd_burst(8'h00, 2);
        rd_burst(8'h04, 2);
        wr_pair(8'h04, 8'h00, 8'h00);
        rd_burst(8'h01, 2);

        cur_req = "R6";   // input ports are read-only
        wr_pair(8'h00, 8'h12, 8'h34);
        rd_burst(8'h00, 2);
        rd_burst(8'h02, 2);
        rd_burst(8'h04, 2);

        cur_req = "R9";   // commands beyond the map
        wr_pair(8'h09, 8'hAA, 8'h55);
        wr_pair(8'hFF, 8'h00, 8'h00);
        rd_burst(8'h08, 3);
        rd_burst(8'hC4, 2);
        rd_burst(8'h02, 2);

        cur_req = "R11";  // bytes after stop and during reads are ignored
        step(1'b0, 1'b0, 1'b1, 8'h11, 1'b0);
        step(1'b0, 1'b0, 1'b1, 8'h22, 1'b0);
        idle(1);
        step(1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
        step(1'b0, 1'b0, 1'b1, 8'h06, 1'b0);
        step(1'b0, 1'b0, 1'b0, 8'h00, 1'b1);
        step(1'b0, 1'b0, 1'b1, 8'h33, 1'b0);
        step(1'b0, 1'b0, 1'b1, 8'h44, 1'b0);
        step(1'b0, 1'b1, 1'b0, 8'h00, 1'b0);
        idle(2);
        rd_burst(8'h06, 2);
        rd_burst(8'h02, 2);

        cur_req = "R10";  // overlapping requests: write byte beats read
        step(1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
        step(1'b0, 1'b0, 1'b1, 8'h02, 1'b1);
        step(1'b0, 1'b0, 1'b1, 8'h77, 1'b1);
        step(1'b0, 1'b0, 1'b0, 8'h00, 1'b1);
        step(1'b1, 1'b0, 1'b0, 8'h00, 1'b1);
        step(1'b0, 1'b1, 1'b0, 8'h00, 1'b1);
        idle(3);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule